// File: doc/BRIEF.md
# Instruction Breakpoint Comparator Bank

This block holds a small, parameterised set of hardware breakpoint units for an instruction fetch path. Each unit has a control register and a 64-bit value register, both loaded through a single-cycle write port. On every fetch the bank compares the fetch program counter and the current privilege level with every unit. It reports a registered hit flag and the index of the matching unit.

Matching works on instruction words. The two lowest bits of the fetch address are ignored. The value register must hold a word-aligned address whose upper bits are a proper sign extension of the highest virtual-address bit in use. A unit only takes part if it is enabled, configured as a plain unlinked address match, has its byte-select field fully set, and its privilege filter admits the current level. When several units match, the one with the lowest index is reported.

Top module: `bkpt_bank`

## Requirements
- R1: After reset `hit` and `hit_idx` are 0 and every unit is disabled, so no fetch hits until software programs a unit (including a fetch at address 0, which equals the reset value register contents).
- R2: A unit matches when all of the following hold: control bit 0 (enable) is 1; value bits 63:2 equal fetch PC bits 63:2; and the other conditions of R3 to R7 are met. Fetch PC bits 1:0 never affect the result.
- R3: Control bits 2:1 filter on privilege, where `fetch_priv` = 1 means kernel and 0 means user. The value 2'b11 admits both levels, 2'b01 admits kernel only, 2'b10 admits user only, and 2'b00 admits neither.
- R4: Control bits 8:5 (byte select) must equal 4'hF. Any other value means the unit never matches.
- R5: Control bits 23:20 (type) and bits 19:16 (link number) must both be 0. A unit with either field non-zero never matches.
- R6: A unit whose value bits 1:0 are non-zero never matches.
- R7: Value bits 63:52 must be all zeros or all ones (a sign extension of bit 52, the highest virtual-address bit in use). Otherwise the unit never matches, even if the fetch PC carries the same bits.
- R8: When several units match one fetch, `hit_idx` gives the lowest matching index.
- R9: `hit` and `hit_idx` update on the clock edge that samples `fetch_valid`, so they are visible one cycle after the fetch strobe. A cycle without `fetch_valid` gives `hit` = 0 on the next cycle. `hit_idx` is 0 whenever `hit` is 0.
- R10: A register write (`wr_is_value` = 1 selects the value register, 0 selects the control register, taken from `wr_data` bits 31:0) affects fetches from the next cycle on. A fetch in the same cycle as the write still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_is_value | input | 1 | 1 writes the value register, 0 writes the control register |
| wr_idx | input | IDX_W | Unit selected by the write |
| wr_data | input | ADDR_W | Write data (control uses bits 31:0) |
| fetch_valid | input | 1 | Fetch strobe |
| fetch_pc | input | ADDR_W | Fetch program counter |
| fetch_priv | input | 1 | 1 kernel level, 0 user level |
| hit | output | 1 | Registered breakpoint hit |
| hit_idx | output | IDX_W | Index of the lowest matching unit, 0 when no hit |

## Verification
The bench sweeps every privilege filter against both privilege levels, every byte-select value, every type and link value, every low-bit pattern of the value register and of the fetch PC, and single-bit flips across the sign-extension bits. Each sweep isolates exactly one gating condition, so a fault in one term cannot be hidden by another. A sweep over all sixteen enable masks of four units that share one address separates lowest-index priority from any other ordering. Directed cycles with the strobe low, and writes that coincide with a fetch, pin down output latency and write visibility.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

   // privilege filter encoding (control bits 2:1)
   typedef enum logic [1:0] {
      PL_NONE = 2'b00,
      PL_KERN = 2'b01,
      PL_USER = 2'b10,
      PL_ANY  = 2'b11
   } plvl_e;

   // bit positions of the control word; software depends on them
   localparam int CTL_EN_BIT  = 0;
   localparam int CTL_PL_LO   = 1;
   localparam int CTL_BSEL_LO = 5;
   localparam int CTL_LINK_LO = 16;
   localparam int CTL_TYPE_LO = 20;
   localparam int CTL_W       = 32;

   localparam logic [3:0] BSEL_FULL = 4'hF;

   typedef struct packed {
      logic [3:0] btype;
      logic [3:0] link;
      logic [3:0] bsel;
      plvl_e      plvl;
      logic       en;
   } bkpt_ctrl_t;

   localparam bkpt_ctrl_t CTRL_RST = '{btype: 4'h0, link: 4'h0, bsel: 4'h0,
                                       plvl: PL_NONE, en: 1'b0};

   function automatic bkpt_ctrl_t decode_ctrl(input logic [CTL_W-1:0] w);
      bkpt_ctrl_t c;
      c.en    = w[CTL_EN_BIT];
      c.plvl  = plvl_e'(w[CTL_PL_LO +: 2]);
      c.bsel  = w[CTL_BSEL_LO +: 4];
      c.link  = w[CTL_LINK_LO +: 4];
      c.btype = w[CTL_TYPE_LO +: 4];
      return c;
   endfunction

endpackage

// File: rtl/bkpt_regfile.sv
module bkpt_regfile
   import bkpt_pkg::*;
#(
   parameter int NUM_UNITS = 4,
   parameter int ADDR_W    = 64,
   parameter int IDX_W     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_is_value,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_data,
   output bkpt_ctrl_t        ctrl_q [NUM_UNITS],
   output logic [ADDR_W-1:0] val_q  [NUM_UNITS]
);

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(u));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctrl_q[u] <= CTRL_RST;
            val_q[u]  <= '0;
         end else if (sel) begin
            if (wr_is_value) val_q[u]  <= wr_data;
            else             ctrl_q[u] <= decode_ctrl(wr_data[CTL_W-1:0]);
         end
      end
   end

endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
   import bkpt_pkg::*;
#(
   parameter int ADDR_W      = 64,
   parameter int VA_MSB      = 52,
   parameter bit CANON_CHECK = 1'b1
) (
   input  bkpt_ctrl_t        ctrl,
   input  logic [ADDR_W-1:0] val,
   input  logic [ADDR_W-1:0] pc,
   input  logic              priv_kern,
   output logic              match
);

   localparam int EXT_W = ADDR_W - VA_MSB;

   logic priv_ok;
   logic canon_ok;
   logic cfg_ok;
   logic addr_ok;

   always_comb begin
      unique case (ctrl.plvl)
         PL_KERN: priv_ok = priv_kern;
         PL_USER: priv_ok = !priv_kern;
         PL_ANY:  priv_ok = 1'b1;
         default: priv_ok = 1'b0;
      endcase
   end

   if (CANON_CHECK) begin : g_canon
      logic [EXT_W-1:0] ext;
      assign ext      = val[ADDR_W-1:VA_MSB];
      assign canon_ok = (ext == '0) || (ext == '1);
   end else begin : g_nocanon
      assign canon_ok = 1'b1;
   end

   assign cfg_ok  = ctrl.en && (ctrl.bsel == BSEL_FULL) &&
                    (ctrl.btype == 4'h0) && (ctrl.link == 4'h0);
   assign addr_ok = (val[1:0] == 2'b00) &&
                    (val[ADDR_W-1:2] == pc[ADDR_W-1:2]);
   assign match   = cfg_ok && priv_ok && canon_ok && addr_ok;

endmodule

// File: rtl/bkpt_prio.sv
module bkpt_prio #(
   parameter int NUM_UNITS = 4,
   parameter int IDX_W     = 2
) (
   input  logic [NUM_UNITS-1:0] req,
   output logic                 any,
   output logic [IDX_W-1:0]     idx
);

   always_comb begin
      any = |req;
      idx = '0;
      for (int i = NUM_UNITS - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/bkpt_bank.sv
module bkpt_bank
   import bkpt_pkg::*;
#(
   parameter int  NUM_UNITS   = 4,
   parameter int  ADDR_W      = 64,
   parameter int  VA_MSB      = 52,
   parameter bit  CANON_CHECK = 1'b1,
   localparam int IDX_W       = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_is_value,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              fetch_valid,
   input  logic [ADDR_W-1:0] fetch_pc,
   input  logic              fetch_priv,
   output logic              hit,
   output logic [IDX_W-1:0]  hit_idx
);

   if (NUM_UNITS < 1 || NUM_UNITS > 16) begin : g_bad_units
      $error("bkpt_bank: NUM_UNITS must lie in 1..16");
   end
   if (ADDR_W < CTL_W || VA_MSB < 2 || VA_MSB >= ADDR_W) begin : g_bad_addr
      $error("bkpt_bank: address width or VA_MSB out of range");
   end

   bkpt_ctrl_t           ctrl_q [NUM_UNITS];
   logic [ADDR_W-1:0]    val_q  [NUM_UNITS];
   logic [NUM_UNITS-1:0] unit_match;
   logic [NUM_UNITS-1:0] unit_en;
   logic                 any_match;
   logic [IDX_W-1:0]     first_idx;

   bkpt_regfile #(
      .NUM_UNITS (NUM_UNITS),
      .ADDR_W    (ADDR_W),
      .IDX_W     (IDX_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_is_value (wr_is_value),
      .wr_idx      (wr_idx),
      .wr_data     (wr_data),
      .ctrl_q      (ctrl_q),
      .val_q       (val_q)
   );

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_cmp
      assign unit_en[u] = ctrl_q[u].en;
      bkpt_unit #(
         .ADDR_W      (ADDR_W),
         .VA_MSB      (VA_MSB),
         .CANON_CHECK (CANON_CHECK)
      ) u_unit (
         .ctrl      (ctrl_q[u]),
         .val       (val_q[u]),
         .pc        (fetch_pc),
         .priv_kern (fetch_priv),
         .match     (unit_match[u])
      );
   end

   bkpt_prio #(
      .NUM_UNITS (NUM_UNITS),
      .IDX_W     (IDX_W)
   ) u_prio (
      .req (unit_match),
      .any (any_match),
      .idx (first_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit     <= 1'b0;
         hit_idx <= '0;
      end else begin
         hit     <= fetch_valid && any_match;
         hit_idx <= (fetch_valid && any_match) ? first_idx : '0;
      end
   end

endmodule

// File: rtl/bkpt_bank_chk.sv
module bkpt_bank_chk #(
   parameter int  NUM_UNITS = 4,
   localparam int IDX_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 fetch_valid,
   input logic                 hit,
   input logic [IDX_W-1:0]     hit_idx,
   input logic [NUM_UNITS-1:0] match_vec,
   input logic [NUM_UNITS-1:0] en_vec
);

   // R9
   idx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (hit_idx == '0));

   // R9
   no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_valid |=> !hit);

   // R2
   hit_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid |=> (hit == $past(|match_vec)));

   // R1
   enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match_vec & ~en_vec) == '0);

   // R8
   lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && match_vec[0]) |=> (hit && hit_idx == '0));

endmodule

bind bkpt_bank bkpt_bank_chk #(.NUM_UNITS(NUM_UNITS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fetch_valid (fetch_valid),
   .hit         (hit),
   .hit_idx     (hit_idx),
   .match_vec   (unit_match),
   .en_vec      (unit_en)
);

// File: tb/bkpt_bank_bench.sv
module bkpt_bank_bench;

   localparam int N = 4;
   localparam logic [31:0] GOOD = 32'h0000_01E7; // en, any level, byte select F
   localparam logic [63:0] BASE = 64'h0000_0000_0040_1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_is_value = 1'b0;
   logic [1:0]  wr_idx = '0;
   logic [63:0] wr_data = '0;
   logic        fetch_valid = 1'b0;
   logic [63:0] fetch_pc = '0;
   logic        fetch_priv = 1'b0;
   logic        hit;
   logic [1:0]  hit_idx;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   logic [31:0] cm [N];
   logic [63:0] vm [N];

   always #2 clk = ~clk; // 250 MHz

   bkpt_bank u_bkpt_bank (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_is_value (wr_is_value),
      .wr_idx (wr_idx), .wr_data (wr_data), .fetch_valid (fetch_valid),
      .fetch_pc (fetch_pc), .fetch_priv (fetch_priv), .hit (hit), .hit_idx (hit_idx)
   );

   function automatic logic [2:0] model(input logic [63:0] pc, input logic kern);
      for (int i = 0; i < N; i++) begin
         logic [31:0] c = cm[i];
         logic [63:0] v = vm[i];
         logic pl_ok = (c[2:1] == 2'b11) || (c[2:1] == 2'b01 && kern) ||
                       (c[2:1] == 2'b10 && !kern);
         logic ext_ok = (v[63:52] == 12'h000) || (v[63:52] == 12'hFFF);
         if (c[0] && pl_ok && c[8:5] == 4'hF && c[23:20] == 4'h0 &&
             c[19:16] == 4'h0 && v[1:0] == 2'b00 && ext_ok &&
             v[63:2] == pc[63:2])
            return {1'b1, 2'(i)};
      end
      return 3'b000;
   endfunction

   task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: hit/idx actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic wr(input bit is_val, input int idx, input logic [63:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_is_value = is_val; wr_idx = 2'(idx); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (is_val) vm[idx] = d; else cm[idx] = d[31:0];
   endtask

   task automatic ft(input logic [63:0] pc, input logic kern, input string tag);
      logic [2:0] e;
      e = model(pc, kern);
      @(negedge clk);
      fetch_valid = 1'b1; fetch_pc = pc; fetch_priv = kern;
      @(negedge clk);
      fetch_valid = 1'b0;
      check(tag, {hit, hit_idx}, e);
   endtask

   task automatic clear_all();
      for (int i = 0; i < N; i++) begin
         wr(1'b0, i, 64'h0);
         wr(1'b1, i, 64'h0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin cm[i] = '0; vm[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state, and address 0 against cleared registers
      check("R1 reset", {hit, hit_idx}, 3'b000);
      ft(64'h0, 1'b1, "R1 disabled after reset");
      ft(64'h0, 1'b0, "R1 disabled after reset");

      // R2: basic match, low PC bits ignored, neighbours miss
      wr(1'b1, 0, BASE);
      wr(1'b0, 0, {32'h0, GOOD});
      for (int lo = 0; lo < 4; lo++) ft(BASE | 64'(lo), 1'b1, "R2 low bits");
      ft(BASE + 64'd4, 1'b1, "R2 next word");
      ft(BASE - 64'd4, 1'b0, "R2 prev word");
      ft(BASE ^ 64'h0000_0800_0000_0000, 1'b0, "R2 high bit differs");

      // R3: privilege filter x level
      for (int p = 0; p < 4; p++) begin
         wr(1'b0, 0, {32'h0, (GOOD & ~32'h6) | 32'(p << 1)});
         ft(BASE, 1'b0, "R3 user");
         ft(BASE, 1'b1, "R3 kernel");
      end

      // R4: byte select sweep
      for (int b = 0; b < 16; b++) begin
         wr(1'b0, 0, {32'h0, (GOOD & ~32'h1E0) | 32'(b << 5)});
         ft(BASE, 1'b1, "R4 byte select");
      end

      // R5: type and link fields
      for (int t = 0; t < 16; t++) begin
         wr(1'b0, 0, {32'h0, GOOD | 32'(t << 20)});
         ft(BASE, 1'b0, "R5 type");
         wr(1'b0, 0, {32'h0, GOOD | 32'(t << 16)});
         ft(BASE, 1'b0, "R5 link");
      end
      wr(1'b0, 0, {32'h0, GOOD});

      // R6: value low bits
      for (int lo = 0; lo < 4; lo++) begin
         wr(1'b1, 0, BASE | 64'(lo));
         ft(BASE, 1'b1, "R6 value low bits");
      end

      // R7: sign extension of the value
      wr(1'b1, 0, 64'hFFF0_0000_0000_1000);
      ft(64'hFFF0_0000_0000_1000, 1'b1, "R7 canonical high");
      for (int k = 52; k < 64; k++) begin
         logic [63:0] v = BASE ^ (64'h1 << k);
         wr(1'b1, 0, v);
         ft(v, 1'b1, "R7 broken extension");
      end
      wr(1'b1, 0, BASE);

      // R8: all enable masks over units sharing one address
      for (int i = 1; i < N; i++) wr(1'b1, i, BASE);
      for (int m = 0; m < 16; m++) begin
         for (int i = 0; i < N; i++)
            wr(1'b0, i, {32'h0, m[i] ? GOOD : (GOOD & ~32'h1)});
         ft(BASE, 1'b0, "R8 priority");
      end

      // R9: output latency and idle cycles
      clear_all();
      wr(1'b1, 2, BASE);
      wr(1'b0, 2, {32'h0, GOOD});
      ft(BASE, 1'b1, "R9 hit after strobe");
      @(negedge clk);
      check("R9 drops when idle", {hit, hit_idx}, 3'b000);
      fetch_valid = 1'b0; fetch_pc = BASE;
      @(negedge clk);
      check("R9 no strobe no hit", {hit, hit_idx}, 3'b000);

      // R10: write coinciding with a fetch uses the old contents
      @(negedge clk);
      wr_en = 1'b1; wr_is_value = 1'b0; wr_idx = 2'd2; wr_data = 64'h0;
      fetch_valid = 1'b1; fetch_pc = BASE; fetch_priv = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; fetch_valid = 1'b0; cm[2] = 32'h0;
      check("R10 same cycle sees old", {hit, hit_idx}, 3'b110);
      ft(BASE, 1'b1, "R10 next cycle sees new");
      @(negedge clk);
      wr_en = 1'b1; wr_is_value = 1'b0; wr_idx = 2'd1; wr_data = {32'h0, GOOD};
      fetch_valid = 1'b1; fetch_pc = 64'h0;
      @(negedge clk);
      wr_en = 1'b0; fetch_valid = 1'b0; cm[1] = GOOD;
      check("R10 enable not yet visible", {hit, hit_idx}, 3'b000);
      ft(64'h0, 1'b0, "R10 enable visible");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule